// File: doc/BRIEF.md
# Stereo Serial Sample Receiver

This block is the digital front end of a two-channel serial audio converter. A single bit clock is shared by both channels. Each channel has its own serial data line and its own latch strobe. On every rising clock edge the current data bit of each channel enters that channel's shift register, most significant bit first. When a channel's strobe is seen to fall, the sixteen most recent bits of that channel move into its output sample register, and a one-cycle update flag is raised for that channel. The samples are 16-bit two's-complement words.

The strobes are sampled in the bit-clock domain. A falling edge is detected by comparing a registered copy of the strobe with its current value. Bits keep shifting while the strobes are idle. A frame longer than sixteen bits therefore keeps only its last sixteen bits, and a frame shorter than sixteen bits keeps older bits in its upper positions. Boards that drive one data line into both inputs, or one strobe into both strobes, get identical behaviour on the two channels.

Top module: `stereo_serial_rx`

## Requirements
- R1: On each rising edge of `clk`, `sdata_l` is shifted into the left shift register. When `strobe_l` is sampled low at an edge after being sampled high at the previous edge, `sample_l` takes the 16 bits captured at the 16 edges before that edge. The earliest of those bits goes to bit 15 and the latest to bit 0.
- R2: The right channel behaves as in R1, using `sdata_r`, `strobe_r` and `sample_r`.
- R3: When more than 16 bits are shifted between two updates, only the final 16 bits appear in the sample. Older bits are dropped.
- R4: Each detected falling strobe edge raises that channel's update flag for exactly one cycle, in the cycle after the edge at which the low strobe was sampled. A strobe that is held low gives no further pulses.
- R5: When no update occurs, the sample register holds its value. Data activity, a high strobe and a rising strobe all leave it unchanged.
- R6: While `rst_n` is low at a clock edge, both samples are cleared to zero (mid-scale) and both update flags are low. A strobe that is high when reset ends does not produce an update.
- R7: The channels are independent. A strobe on one channel never updates the other channel's sample or flag.
- R8: When the same data is driven on both data inputs and the same strobe on both strobes, both channels update in the same cycle with identical samples.
- R9: When fewer than 16 bits are shifted after an update, the new bits fill the low positions and the bits shifted before them move up into the high positions.
- R10: Words sent back to back, with the strobe low for a single cycle that overlaps the first bit of the next word, are each received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bit clock; data and strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sdata_l | input | 1 | Left serial data, MSB first |
| sdata_r | input | 1 | Right serial data, MSB first |
| strobe_l | input | 1 | Left latch strobe; a falling edge loads the left sample |
| strobe_r | input | 1 | Right latch strobe; a falling edge loads the right sample |
| sample_l | output | WORD_W | Left two's-complement sample |
| sample_r | output | WORD_W | Right two's-complement sample |
| upd_l | output | 1 | One-cycle pulse when the left sample is loaded |
| upd_r | output | 1 | One-cycle pulse when the right sample is loaded |

## Verification
The assertions check four things on every cycle. Each update is a single-cycle pulse, and it is preceded by a high-then-low strobe sample. The sample's lowest bit is the data bit captured at the edge just before the strobe edge. Between updates the sample holds still. Only the bench scenarios can show the full 16-bit word contents, the effect of long and short frames, the independence of the channels, and the tied-input and back-to-back cases. For these, the bench compares every output, every cycle, against a history of the bits it drove.

// File: rtl/stereo_rx_pkg.sv
// Shared definitions for the stereo serial sample receiver.
package stereo_rx_pkg;
    // Channel index: left is bit 0 of every per-channel vector.
    typedef enum int unsigned {
        CH_LEFT  = 0,
        CH_RIGHT = 1
    } chan_e;

    localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/serial_shifter.sv
// Serial-in shift register for one channel.
// Shifts din in at the LSB on every rising clock edge, so the oldest bit
// moves toward the MSB. Assumes din is already synchronous to clk.
module serial_shifter #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic [WIDTH-1:0] word
);
    // Shift one bit per clock; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) word <= '0;
        else        word <= {word[WIDTH-2:0], din};
    end
endmodule

// File: rtl/strobe_fall_det.sv
// Falling-edge detector for a latch strobe sampled in the bit-clock domain.
// The registered copy resets low, so a strobe that is high when reset ends
// produces no edge. Assumes the strobe is synchronous to clk.
module strobe_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic fall
);
    logic strobe_q;

    // Keep the strobe value seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // An edge is high at the previous sample and low now.
    always_comb fall = strobe_q & ~strobe;
endmodule

// File: rtl/word_latch.sv
// Output holding register for one channel, with its update pulse.
// Loads word_in when load is high and raises upd for that one cycle.
// Assumes load is a single-cycle request.
module word_latch #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] word_in,
    output logic [WIDTH-1:0] word_out,
    output logic             upd
);
    // Capture the word on a load; reset to mid-scale zero.
    always_ff @(posedge clk) begin
        if (!rst_n)    word_out <= '0;
        else if (load) word_out <= word_in;
    end

    // Register the load request as the update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) upd <= 1'b0;
        else        upd <= load;
    end
endmodule

// File: rtl/stereo_serial_rx.sv
// Top level of the stereo serial sample receiver.
// Builds one shift register, strobe edge detector and holding register per
// channel. All inputs are assumed synchronous to the shared bit clock.
module stereo_serial_rx
    import stereo_rx_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata_l,
    input  logic              sdata_r,
    input  logic              strobe_l,
    input  logic              strobe_r,
    output logic [WORD_W-1:0] sample_l,
    output logic [WORD_W-1:0] sample_r,
    output logic              upd_l,
    output logic              upd_r
);
    localparam int unsigned IDX_L = int'(CH_LEFT);
    localparam int unsigned IDX_R = int'(CH_RIGHT);

    logic [NUM_CH-1:0] din_v;
    logic [NUM_CH-1:0] stb_v;
    logic [NUM_CH-1:0] fall_v;
    logic [NUM_CH-1:0] upd_v;
    logic [WORD_W-1:0] shift_v [NUM_CH];
    logic [WORD_W-1:0] hold_v  [NUM_CH];

    // Gather the per-channel pins into vectors indexed by channel.
    always_comb begin
        din_v[IDX_L] = sdata_l;
        din_v[IDX_R] = sdata_r;
        stb_v[IDX_L] = strobe_l;
        stb_v[IDX_R] = strobe_r;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        serial_shifter #(.WIDTH(WORD_W)) u_shift (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (din_v[ch]),
            .word  (shift_v[ch])
        );

        strobe_fall_det u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (stb_v[ch]),
            .fall   (fall_v[ch])
        );

        word_latch #(.WIDTH(WORD_W)) u_hold (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (fall_v[ch]),
            .word_in  (shift_v[ch]),
            .word_out (hold_v[ch]),
            .upd      (upd_v[ch])
        );
    end

    // Drive the output pins from the channel vectors.
    always_comb begin
        sample_l = hold_v[IDX_L];
        sample_r = hold_v[IDX_R];
        upd_l    = upd_v[IDX_L];
        upd_r    = upd_v[IDX_R];
    end
endmodule

// File: rtl/stereo_serial_rx_chk.sv
// Property checker for stereo_serial_rx, attached by bind below.
module stereo_serial_rx_chk #(
    parameter int unsigned WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sdata_l,
    input logic              sdata_r,
    input logic              strobe_l,
    input logic              strobe_r,
    input logic [WORD_W-1:0] sample_l,
    input logic [WORD_W-1:0] sample_r,
    input logic              upd_l,
    input logic              upd_r
);
    // R4: update pulses last one cycle.
    p_pulse_one_l_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_l |=> !upd_l);
    p_pulse_one_r_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_r |=> !upd_r);

    // R5: samples hold while no update is flagged.
    p_hold_l_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_l |-> $stable(sample_l));
    p_hold_r_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_r |-> $stable(sample_r));

    // R1: a left update follows a high-then-low strobe sample.
    p_after_fall_l_r1: assert property (@(posedge clk) disable iff (!rst_n)
        upd_l |-> ($past(strobe_l, 2) && !$past(strobe_l)));
    // R2: same for the right channel.
    p_after_fall_r_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_r |-> ($past(strobe_r, 2) && !$past(strobe_r)));

    // R1: the sample LSB is the bit captured just before the strobe edge.
    p_lsb_l_r1: assert property (@(posedge clk) disable iff (!rst_n)
        upd_l |-> (sample_l[0] == $past(sdata_l, 2)));
    // R2: same for the right channel.
    p_lsb_r_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_r |-> (sample_r[0] == $past(sdata_r, 2)));
endmodule

bind stereo_serial_rx stereo_serial_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sdata_l  (sdata_l),
    .sdata_r  (sdata_r),
    .strobe_l (strobe_l),
    .strobe_r (strobe_r),
    .sample_l (sample_l),
    .sample_r (sample_r),
    .upd_l    (upd_l),
    .upd_r    (upd_r)
);

// File: tb/stereo_serial_rx_test.sv
module stereo_serial_rx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdata_l = 1'b0, sdata_r = 1'b0;
    logic        strobe_l = 1'b1, strobe_r = 1'b1;
    logic [15:0] sample_l, sample_r;
    logic        upd_l, upd_r;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R6";

    // Reference model: bit history and pending update per channel.
    logic [31:0] hist_l = '0, hist_r = '0;
    logic        prev_sl = 1'b0, prev_sr = 1'b0;
    logic        pend_l = 1'b0, pend_r = 1'b0;
    logic [15:0] exp_l = '0, exp_r = '0, last_l = '0, last_r = '0;

    always #2.5 clk = ~clk;

    stereo_serial_rx #(.WORD_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .sdata_l(sdata_l), .sdata_r(sdata_r),
        .strobe_l(strobe_l), .strobe_r(strobe_r),
        .sample_l(sample_l), .sample_r(sample_r),
        .upd_l(upd_l), .upd_r(upd_r));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // One cycle: check outputs of the last edge, then drive and update model.
    task automatic tick(input logic dl, input logic dr, input logic sl, input logic sr);
        @(negedge clk);
        if (pend_l) last_l = exp_l;
        if (pend_r) last_r = exp_r;
        check(upd_l == pend_l, cur_req, "upd_l", 32'(upd_l), 32'(pend_l));
        check(sample_l == last_l, cur_req, "sample_l", 32'(sample_l), 32'(last_l));
        check(upd_r == pend_r, cur_req, "upd_r", 32'(upd_r), 32'(pend_r));
        check(sample_r == last_r, cur_req, "sample_r", 32'(sample_r), 32'(last_r));
        sdata_l = dl; sdata_r = dr; strobe_l = sl; strobe_r = sr;
        pend_l = prev_sl & ~sl;
        pend_r = prev_sr & ~sr;
        exp_l = hist_l[15:0];
        exp_r = hist_r[15:0];
        hist_l = {hist_l[30:0], dl};
        hist_r = {hist_r[30:0], dr};
        prev_sl = sl; prev_sr = sr;
    endtask

    // Shift n bits (MSB first) with both strobes high.
    task automatic shift(input logic [31:0] lw, input logic [31:0] rw, input int n);
        for (int i = n - 1; i >= 0; i--) tick(lw[i], rw[i], 1'b1, 1'b1);
    endtask

    // Pulse the selected strobes low for one cycle, then idle one cycle.
    task automatic latch(input logic do_l, input logic do_r);
        tick(1'b0, 1'b0, ~do_l, ~do_r);
        tick(1'b0, 1'b0, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R6: reset state, with strobes driven low then high during reset.
        strobe_l = 1'b0; strobe_r = 1'b0;
        repeat (3) @(negedge clk);
        strobe_l = 1'b1; strobe_r = 1'b1; sdata_l = 1'b1; sdata_r = 1'b1;
        repeat (2) @(negedge clk);
        check(sample_l == 0 && sample_r == 0, "R6", "reset samples",
              {sample_l, sample_r}, 32'h0);
        check(!upd_l && !upd_r, "R6", "reset flags", 32'({upd_l, upd_r}), 32'h0);
        sdata_l = 1'b0; sdata_r = 1'b0;
        rst_n = 1'b1;
        repeat (4) tick(1'b0, 1'b0, 1'b1, 1'b1);

        // R1 R2: full words, both channels, distinct patterns.
        cur_req = "R1/R2";
        for (int k = 0; k < 300; k++) begin
            shift(32'((k * 40503 + 7) & 16'hFFFF), 32'(~(k * 2654) & 16'hFFFF), 16);
            latch(1'b1, 1'b1);
        end
        // R1 R2: walking one and corner codes.
        for (int b = 0; b < 16; b++) begin
            shift(32'(16'h1 << b), 32'(~(16'h1 << b) & 16'hFFFF), 16);
            latch(1'b1, 1'b1);
        end

        // R7: one channel at a time.
        cur_req = "R7";
        for (int k = 0; k < 40; k++) begin
            shift(32'(k * 977), 32'(k * 3301), 16);
            latch(k[0], ~k[0]);
        end

        // R3: long frames, only the final 16 bits kept.
        cur_req = "R3";
        for (int n = 17; n <= 32; n++) begin
            shift(32'hA5C3_0000 | 32'(n * 1234), 32'h3C5A_0000 ^ 32'(n * 777), n);
            latch(1'b1, 1'b1);
        end

        // R9: short frames, older bits move up.
        cur_req = "R9";
        for (int n = 1; n <= 15; n++) begin
            shift(32'(n * 13), 32'(n * 29), n);
            latch(1'b1, 1'b1);
        end

        // R4: strobe held low for several cycles gives one pulse.
        cur_req = "R4";
        shift(32'h1234, 32'hFEDC, 16);
        repeat (6) tick(1'b1, 1'b0, 1'b0, 1'b0);
        repeat (2) tick(1'b0, 1'b0, 1'b1, 1'b1);

        // R5: data activity and rising strobes leave samples alone.
        cur_req = "R5";
        for (int k = 0; k < 64; k++) tick(k[0], k[1], 1'b1, 1'b1);
        tick(1'b1, 1'b1, 1'b0, 1'b1);
        for (int k = 0; k < 8; k++) tick(k[0], ~k[0], 1'b1, 1'b1);

        // R8: tied data and tied strobes.
        cur_req = "R8";
        for (int k = 0; k < 32; k++) begin
            shift(32'(k * 2017), 32'(k * 2017), 16);
            tick(1'b0, 1'b0, 1'b0, 1'b0);
            tick(1'b0, 1'b0, 1'b1, 1'b1);
            check(sample_l == sample_r && upd_l == upd_r, "R8", "tied equality",
                  {sample_l, sample_r}, {sample_r, sample_r});
        end

        // R10: back to back words, strobe low during the next word's MSB.
        cur_req = "R10";
        for (int k = 0; k < 20; k++) begin
            logic [15:0] wl = 16'(k * 3119 + 16'h8000);
            logic [15:0] wr = 16'(16'h7FFF - k * 511);
            tick(wl[15], wr[15], 1'b0, 1'b0);
            for (int i = 14; i >= 0; i--) tick(wl[i], wr[i], 1'b1, 1'b1);
        end
        latch(1'b1, 1'b1);
        repeat (2) tick(1'b0, 1'b0, 1'b1, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule